// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Unit

This unit gathers per-channel events from the engines of a 16-channel DMA controller and exposes them to software through a small word-addressed register bus. One sticky register records completions. Four further sticky registers record the error classes: stalled bursts, request timeouts, transfer faults and buffer overruns. A mask register decides which channels may drive the main interrupt line. A separate error line reports any pending error, whatever the mask holds. Software clears a status bit by writing a 1 to it.

Each channel also has a burst watchdog. A burst start loads the watchdog from a shared programmable limit, and each clock in which the channel reports a stall counts the watchdog down. If the count runs out while the watchdog is enabled, the unit flags the stalled-burst error for that channel and sends the engine a one-cycle abort. A control register holds a global enable output and a self-clearing soft reset that returns the whole unit to its power-up state.

Top module: `dma_irq_status`

## Requirements
- R1: After the asynchronous reset, every status register reads 0, the mask reads 0x0000FFFF, the control and watchdog-limit registers read 0, and `irq_o`, `err_irq_o`, `dma_en_o` and `burst_abort_o` are low.
- R2: An event pulse on a channel sets that channel's bit at the next clock edge, whatever the mask holds. The registers and their word offsets are: completion at 0x04, stalled burst at 0x0C, request timeout at 0x10, transfer fault at 0x14 and buffer overrun at 0x18. Bit n corresponds to channel n.
- R3: Writing a word to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set. Other bits cleared by the same write still clear.
- R5: The mask register is at offset 0x08, and bit n set to 1 masks channel n. `irq_o` is high exactly when some channel has a bit set in any of the five status registers and its mask bit is 0.
- R6: `err_irq_o` is high exactly when any bit of the four error registers is set. The mask has no effect on it.
- R7: The control register is at offset 0x00. Bit 0 is the enable, which drives `dma_en_o`. Writing 1 to bit 1 makes bit 1 read 1 for one cycle. At the following edge, every register returns to its R1 value and bit 1 clears itself.
- R8: The watchdog register is at offset 0x1C. Bit 15 enables the watchdog and bits 14:0 hold the limit L. Bits above 15 are ignored on write and read as 0.
- R9: Once a channel's burst start has been sampled, the watchdog expires at the L-th sampled stall cycle (the first for L of 0 or 1). Cycles without a stall do not count. Expiry sets the channel's stalled-burst bit and raises its `burst_abort_o` for exactly one cycle, at the same edge. With bit 15 at 0, the watchdog never expires.
- R10: A burst end sampled before expiry disarms the watchdog. A new burst start reloads it with L, and counting restarts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte address; bits 4:2 select the word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| done_evt_i | input | 16 | Per-channel completion pulses |
| req_tmo_evt_i | input | 16 | Per-channel request timeout pulses |
| xfer_err_evt_i | input | 16 | Per-channel transfer fault pulses |
| buf_ovf_evt_i | input | 16 | Per-channel buffer overrun pulses |
| burst_start_i | input | 16 | Per-channel burst start pulses |
| burst_stall_i | input | 16 | Per-channel stall level |
| burst_end_i | input | 16 | Per-channel burst end pulses |
| burst_abort_o | output | 16 | Per-channel one-cycle abort on watchdog expiry |
| dma_en_o | output | 1 | Global enable from control bit 0 |
| irq_o | output | 1 | Unmasked status interrupt |
| err_irq_o | output | 1 | Error-pending interrupt |

## Verification
Status bits are set on several channels while the mask is fully set and then partly cleared. This separates event capture from interrupt gating, and it shows that the error line ignores the mask. Clearing writes carry mixed one and zero patterns, and one of them lands in the same cycle as an event on another bit, which separates write-one-to-clear from plain overwrite and shows which side wins. The watchdog runs with unbroken stalls, with stalls broken by gaps, with limits of 0 and 3, with the enable off, and with a mid-burst end or restart. Each pattern places the expected abort in a different cycle, so an off-by-one count or a missing reload is caught. A soft reset issued with state present in every register must return all of them to the power-up values.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_STAT = 5;  // completion + four error classes

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_MASK = 3'd2,
    REG_BTO  = 3'd3,
    REG_RTO  = 3'd4,
    REG_XERR = 3'd5,
    REG_BOVF = 3'd6,
    REG_TCTL = 3'd7
  } reg_idx_e;

  // status source order inside the unit
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_BTO  = 1;
endpackage

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= '0;
    else if (clr_all_i) q_q <= '0;
    else                q_q <= (q_q & ~clr_i) | set_i;  // set dominates
  end

  assign q_o = q_q;

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && |set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));  // R4

  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));  // R3
endmodule

// File: rtl/burst_tmo_ctr.sv
module burst_tmo_ctr #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             start_i,
  input  logic             stall_i,
  input  logic             end_i,
  output logic             fire_o,
  output logic             abort_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             abort_q;
  logic             expire;

  // last stalled cycle of the window; start and end take precedence
  assign expire = act_q & stall_i & en_i & (cnt_q <= CNT_W'(1))
                & ~start_i & ~end_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      abort_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= expire;
      if (start_i) begin
        cnt_q <= limit_i;
        act_q <= 1'b1;
      end else if (end_i || expire) begin
        act_q <= 1'b0;
      end else if (act_q && stall_i && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign fire_o  = expire;
  assign abort_o = abort_q;

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);  // R9

  AST_NO_ABORT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !abort_o);  // R9
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned TMO_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] req_tmo_evt_i,
  input  logic [NUM_CH-1:0] xfer_err_evt_i,
  input  logic [NUM_CH-1:0] buf_ovf_evt_i,
  input  logic [NUM_CH-1:0] burst_start_i,
  input  logic [NUM_CH-1:0] burst_stall_i,
  input  logic [NUM_CH-1:0] burst_end_i,
  output logic [NUM_CH-1:0] burst_abort_o,
  output logic              dma_en_o,
  output logic              irq_o,
  output logic              err_irq_o
);
  localparam int unsigned CH_PAD  = DATA_W - NUM_CH;
  localparam int unsigned TC_PAD  = DATA_W - TMO_W - 1;

  reg_idx_e idx;
  logic     wr;
  logic     soft_rst_q;
  logic     en_q;
  logic     tctl_en_q;
  logic [TMO_W-1:0]  tctl_lim_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] bto_fire;
  logic [NUM_STAT-1:0][NUM_CH-1:0] stat_set;
  logic [NUM_STAT-1:0][NUM_CH-1:0] stat_q;
  logic [NUM_CH-1:0] any_stat;
  logic [NUM_CH-1:0] any_err;
  logic unused_bits;

  assign idx = reg_idx_e'(reg_addr_i[ADDR_W-1:2]);
  assign wr  = reg_we_i & ~soft_rst_q;  // bus writes dropped during soft reset
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[DATA_W-1:NUM_CH]};

  assign stat_set[ST_DONE] = done_evt_i;
  assign stat_set[ST_BTO]  = bto_fire;
  assign stat_set[2]       = req_tmo_evt_i;
  assign stat_set[3]       = xfer_err_evt_i;
  assign stat_set[4]       = buf_ovf_evt_i;

  // status registers: completion at word 1, errors at words 3..6
  for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
    localparam logic [2:0] RIDX = (s == 0) ? 3'd1 : 3'(2 + s);
    logic [NUM_CH-1:0] clr;
    assign clr = (wr && idx == reg_idx_e'(RIDX)) ? reg_wdata_i[NUM_CH-1:0] : '0;
    w1c_status_reg #(.W(NUM_CH)) u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_all_i (soft_rst_q),
      .set_i     (stat_set[s]),
      .clr_i     (clr),
      .q_o       (stat_q[s])
    );
  end

  // per-channel burst watchdogs
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctr
    burst_tmo_ctr #(.CNT_W(TMO_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (soft_rst_q),
      .en_i    (tctl_en_q),
      .limit_i (tctl_lim_q),
      .start_i (burst_start_i[c]),
      .stall_i (burst_stall_i[c]),
      .end_i   (burst_end_i[c]),
      .fire_o  (bto_fire[c]),
      .abort_o (burst_abort_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_rst_q <= 1'b0;
      en_q       <= 1'b0;
      mask_q     <= '1;
      tctl_en_q  <= 1'b0;
      tctl_lim_q <= '0;
    end else if (soft_rst_q) begin
      soft_rst_q <= 1'b0;
      en_q       <= 1'b0;
      mask_q     <= '1;
      tctl_en_q  <= 1'b0;
      tctl_lim_q <= '0;
    end else begin
      soft_rst_q <= wr && idx == REG_CTRL && reg_wdata_i[1];
      if (wr && idx == REG_CTRL) en_q <= reg_wdata_i[0];
      if (wr && idx == REG_MASK) mask_q <= reg_wdata_i[NUM_CH-1:0];
      if (wr && idx == REG_TCTL) begin
        tctl_en_q  <= reg_wdata_i[TMO_W];
        tctl_lim_q <= reg_wdata_i[TMO_W-1:0];
      end
    end
  end

  always_comb begin
    case (idx)
      REG_CTRL: reg_rdata_o = {{(DATA_W-2){1'b0}}, soft_rst_q, en_q};
      REG_STAT: reg_rdata_o = {{CH_PAD{1'b0}}, stat_q[ST_DONE]};
      REG_MASK: reg_rdata_o = {{CH_PAD{1'b0}}, mask_q};
      REG_BTO:  reg_rdata_o = {{CH_PAD{1'b0}}, stat_q[1]};
      REG_RTO:  reg_rdata_o = {{CH_PAD{1'b0}}, stat_q[2]};
      REG_XERR: reg_rdata_o = {{CH_PAD{1'b0}}, stat_q[3]};
      REG_BOVF: reg_rdata_o = {{CH_PAD{1'b0}}, stat_q[4]};
      REG_TCTL: reg_rdata_o = {{TC_PAD{1'b0}}, tctl_en_q, tctl_lim_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    any_stat = '0;
    any_err  = '0;
    for (int s = 0; s < NUM_STAT; s++) begin
      any_stat = any_stat | stat_q[s];
      if (s != ST_DONE) any_err = any_err | stat_q[s];
    end
  end

  assign irq_o     = |(any_stat & ~mask_q);
  assign err_irq_o = |any_err;
  assign dma_en_o  = en_q;

  AST_FULL_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);  // R5

  AST_ABORT_FLAGS_BTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|burst_abort_o) |-> ((stat_q[ST_BTO] & burst_abort_o) == burst_abort_o));  // R9

  AST_SOFT_RST_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_q |=> ((&mask_q) && stat_q == '0 && !dma_en_o && !soft_rst_q));  // R7

  AST_ERR_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (stat_q[1] != '0 || stat_q[2] != '0 || stat_q[3] != '0 || stat_q[4] != '0));  // R6
endmodule

// File: tb/tb_dma_irq_status.sv
`timescale 1ns/1ps
module tb_dma_irq_status;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] done_evt = '0, rto_evt = '0, xerr_evt = '0, bovf_evt = '0;
  logic [NCH-1:0] bstart = '0, bstall = '0, bend = '0;
  logic [NCH-1:0] abort;
  logic dma_en, irq, err_irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;
  item_t exp_q[$];
  item_t it;

  always #10 clk = ~clk;  // 50 MHz

  dma_irq_status dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .done_evt_i(done_evt), .req_tmo_evt_i(rto_evt), .xfer_err_evt_i(xerr_evt),
    .buf_ovf_evt_i(bovf_evt), .burst_start_i(bstart), .burst_stall_i(bstall),
    .burst_end_i(bend), .burst_abort_o(abort), .dma_en_o(dma_en),
    .irq_o(irq), .err_irq_o(err_irq)
  );

  // monitor: pops expected register reads and compares mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      checks++;
      if (addr !== it.a || rdata !== it.e) begin
        errors++;
        $display("FAIL %s @%h actual %h expected %h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    exp_q.push_back('{a: a, e: e, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic pulse(input int which, input logic [NCH-1:0] v);
    @(posedge clk); #1;
    case (which)
      0: done_evt = v;
      1: rto_evt  = v;
      2: xerr_evt = v;
      default: bovf_evt = v;
    endcase
    @(posedge clk); #1;
    done_evt = '0; rto_evt = '0; xerr_evt = '0; bovf_evt = '0;
  endtask

  // burst: start sampled first, then per-cycle stall/end/start patterns
  task automatic burst(input int ch, input int n, input logic [15:0] stall_p,
                       input logic [15:0] end_p, input logic [15:0] start_p,
                       input int fire_idx, input string tag);
    @(posedge clk); #1;
    bstart[ch] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i > 0) chk({31'd0, abort[ch]}, {31'd0, (i - 1) == fire_idx}, tag);
      bstart[ch] = start_p[i];
      bstall[ch] = stall_p[i];
      bend[ch]   = end_p[i];
    end
    @(posedge clk); #1;
    chk({31'd0, abort[ch]}, {31'd0, (n - 1) == fire_idx}, tag);
    bstart[ch] = 1'b0; bstall[ch] = 1'b0; bend[ch] = 1'b0;
    @(posedge clk); #1;
    chk({16'd0, abort}, 32'd0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    chk({29'd0, irq, err_irq, dma_en}, 32'd0, "R1 outputs");
    chk({16'd0, abort}, 32'd0, "R1 abort");
    rd(5'h00, 32'h0, "R1 ctrl");
    rd(5'h04, 32'h0, "R1 stat");
    rd(5'h08, 32'h0000FFFF, "R1 mask");
    rd(5'h0C, 32'h0, "R1 bto");
    rd(5'h10, 32'h0, "R1 rto");
    rd(5'h14, 32'h0, "R1 xerr");
    rd(5'h18, 32'h0, "R1 bovf");
    rd(5'h1C, 32'h0, "R1 tctl");

    // R2 completion captured although masked
    pulse(0, 16'h0005);
    rd(5'h04, 32'h0005, "R2 done while masked");
    chk({31'd0, irq}, 32'd0, "R5 masked irq low");

    // R5 mask gating
    wr(5'h08, 32'h0000FFFE);
    chk({31'd0, irq}, 32'd1, "R5 ch0 unmasked");
    wr(5'h08, 32'h0000FFFD);
    chk({31'd0, irq}, 32'd0, "R5 ch1 unmasked no status");
    wr(5'h08, 32'h0000FFFB);
    chk({31'd0, irq}, 32'd1, "R5 ch2 unmasked");

    // R3 write-one-to-clear
    wr(5'h04, 32'h0001);
    rd(5'h04, 32'h0004, "R3 clear bit0");
    wr(5'h04, 32'h0000);
    rd(5'h04, 32'h0004, "R3 zero keeps");
    wr(5'h04, 32'h0004);
    rd(5'h04, 32'h0000, "R3 clear bit2");
    chk({31'd0, irq}, 32'd0, "R5 irq drops after clear");

    // R2 / R6 error registers
    wr(5'h08, 32'h0000FFFF);
    pulse(1, 16'h0010);
    pulse(2, 16'h0100);
    pulse(3, 16'h8000);
    rd(5'h10, 32'h0010, "R2 rto");
    rd(5'h14, 32'h0100, "R2 xerr");
    rd(5'h18, 32'h8000, "R2 bovf");
    rd(5'h04, 32'h0000, "R2 done untouched");
    chk({31'd0, err_irq}, 32'd1, "R6 err irq despite mask");
    chk({31'd0, irq}, 32'd0, "R5 errors masked");
    wr(5'h08, 32'h00007FFF);
    chk({31'd0, irq}, 32'd1, "R5 error bit unmasked");
    wr(5'h10, 32'hFFFF);
    wr(5'h14, 32'h0100);
    chk({31'd0, err_irq}, 32'd1, "R6 one error left");
    wr(5'h18, 32'h8000);
    chk({31'd0, err_irq}, 32'd0, "R6 all cleared");

    // R4 event beats same-cycle clear
    pulse(0, 16'h0002);
    @(posedge clk); #1;
    we = 1'b1; addr = 5'h04; wdata = 32'h000A; done_evt = 16'h0008;
    @(posedge clk); #1;
    we = 1'b0; done_evt = '0;
    rd(5'h04, 32'h0008, "R4 event wins");
    wr(5'h04, 32'h0008);

    // R8 watchdog register
    wr(5'h1C, 32'hFFFF0005);
    rd(5'h1C, 32'h0000FFFF & 32'hFFFF0005, "R8 upper ignored");
    wr(5'h1C, 32'h00008003);
    rd(5'h1C, 32'h00008003, "R8 readback");

    // R9 expiry timing, L=3
    burst(2, 4, 16'b1111, 16'b0, 16'b0, 2, "R9 steady stall");
    burst(5, 5, 16'b11101, 16'b0, 16'b0, 3, "R9 stall gaps");
    // R10 end disarms, restart reloads
    burst(9, 6, 16'b111011, 16'b000100, 16'b0, -1, "R10 end disarms");
    burst(10, 6, 16'b111011, 16'b0, 16'b000100, 5, "R10 restart reloads");
    // R9 disabled watchdog
    wr(5'h1C, 32'h00000003);
    burst(7, 6, 16'b111111, 16'b0, 16'b0, -1, "R9 disabled");
    // R9 limit zero
    wr(5'h1C, 32'h00008000);
    burst(12, 2, 16'b11, 16'b0, 16'b0, 0, "R9 limit zero");
    rd(5'h0C, 32'h00001424, "R9 bto bits");
    chk({31'd0, err_irq}, 32'd1, "R6 bto raises err irq");

    // R7 enable and soft reset
    wr(5'h00, 32'h1);
    rd(5'h00, 32'h1, "R7 enable reads");
    chk({31'd0, dma_en}, 32'd1, "R7 dma_en high");
    pulse(0, 16'h0400);
    wr(5'h08, 32'h0);
    @(posedge clk); #1;
    we = 1'b1; addr = 5'h00; wdata = 32'h3;
    @(posedge clk); #1;
    we = 1'b0;
    chk(rdata, 32'h3, "R7 reset bit visible");
    rd(5'h00, 32'h0, "R7 ctrl self-clears");
    rd(5'h04, 32'h0, "R7 stat cleared");
    rd(5'h08, 32'h0000FFFF, "R7 mask set");
    rd(5'h0C, 32'h0, "R7 bto cleared");
    rd(5'h1C, 32'h0, "R7 tctl cleared");
    chk({30'd0, irq, dma_en}, 32'd0, "R7 outputs low");

    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule